// File: doc/BRIEF.md
# Subroutine Frame Sequencer

This block carries out the memory side of subroutine entry and exit for a small 32-bit processor. On a call it pushes a two-word linkage area: the return address plus one spare word kept for a static-chain pointer. It then pushes the caller's frame pointer and makes the new stack top the callee's frame pointer. On a return it unwinds that frame from the frame pointer and recovers the caller's frame pointer, the return PC and the caller's stack pointer.

The core pulses `start_i` with an operation code, the current PC, the candidate targets and the current frame and stack pointers. The sequencer then runs single-word accesses on a simple request/ready memory port, one at a time. When the last access completes it presents the new frame pointer, stack pointer and PC and raises `done_o` for one cycle. All other register traffic stays with the core.

Top module: `frame_seq`

## Requirements
- R1: After reset `fp_o`, `sp_o` and `pc_o` are zero, and `done_o`, `busy_o` and `mem_req_o` are low.
- R2: Operation codes on `op_i` are 2'b00 call to the immediate target, 2'b01 call to the register target, and 2'b10 return. A `start_i` pulse carrying 2'b11 leaves the block idle and changes no output.
- R3: The first access of a call writes the return address to sp-8. The return address is PC+6 for the immediate call and PC+2 for the register call.
- R4: The second access of a call writes the caller's frame pointer to sp-12. The call then ends with `fp_o` = `sp_o` = sp-12 and `pc_o` equal to the immediate (code 00) or the register target (code 01).
- R5: A return reads the word at fp as the new frame pointer, then reads the word at fp+4 as the new PC. It ends with `sp_o` = fp+12, so the static-chain word is skipped.
- R6: While `mem_req_o` is high and `mem_ready_i` is low, the request, address, write enable and write data hold steady and the sequence does not advance. `mem_req_o` is high only while busy.
- R7: `done_o` is high for exactly one cycle, the cycle after the final access completes, and `busy_o` is low in that cycle. Between operations `fp_o`, `sp_o` and `pc_o` hold their values.
- R8: A `start_i` pulse that arrives while busy is ignored. The running operation completes with its own operands and no extra access is made.
- R9: A call followed by its matching return restores the caller's sp and fp exactly. Nested calls leave a chain in which each frame's first word holds the previous frame pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse for one operation |
| op_i | input | 2 | Operation code (see R2) |
| pc_i | input | 32 | PC of the call instruction |
| imm_i | input | 32 | Absolute call target |
| reg_tgt_i | input | 32 | Register call target |
| fp_i | input | 32 | Current frame pointer |
| sp_i | input | 32 | Current stack pointer |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write enable for the access |
| mem_addr_o | output | 32 | Byte address of the word |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with ready |
| mem_ready_i | input | 1 | Access completes on this edge |
| fp_o | output | 32 | Frame pointer result |
| sp_o | output | 32 | Stack pointer result |
| pc_o | output | 32 | PC result |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Sequence in progress |

## Verification
The bound checker checks four properties on every cycle: the memory request stays frozen while ready is low, requests appear only while busy, done is a single-cycle pulse with busy low, and a start during a busy run cannot end it early. It also checks that every finished call leaves the frame and stack pointers equal. The address and data of each access, the return-address offsets of the two call forms, and the values recovered on a return can only be shown by the bench's scenarios. The same holds for exact restoration after call/return pairs and the frame chain built by nested calls, which the bench compares against a behavioural memory and frame model under both steady and irregular ready patterns.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;

    typedef enum logic [1:0] {
        FS_CALL_IMM = 2'b00,
        FS_CALL_REG = 2'b01,
        FS_RETURN   = 2'b10,
        FS_NOP      = 2'b11
    } fs_op_e;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_PUSH_LINK  = 3'd1,
        ST_PUSH_FRAME = 3'd2,
        ST_POP_FRAME  = 3'd3,
        ST_POP_LINK   = 3'd4
    } fs_state_e;

endpackage

// File: rtl/frame_seq_launch.sv
module frame_seq_launch
    import frame_seq_pkg::*;
#(
    parameter int XLEN        = 32,
    parameter int SHORT_BYTES = 2,
    parameter int LONG_BYTES  = 6
) (
    input  logic [1:0]      op_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] imm_i,
    input  logic [XLEN-1:0] reg_tgt_i,
    output logic [XLEN-1:0] ret_addr_o,
    output logic [XLEN-1:0] target_o
);
    localparam logic [XLEN-1:0] SHORT_STEP = XLEN'(SHORT_BYTES);
    localparam logic [XLEN-1:0] LONG_STEP  = XLEN'(LONG_BYTES);

    fs_op_e op;

    always_comb begin
        op = fs_op_e'(op_i);
        if (op == FS_CALL_IMM) begin
            // immediate form carries a trailing 32-bit word
            ret_addr_o = pc_i + LONG_STEP;
            target_o   = imm_i;
        end else begin
            ret_addr_o = pc_i + SHORT_STEP;
            target_o   = reg_tgt_i;
        end
    end
endmodule

// File: rtl/frame_seq_ctrl.sv
module frame_seq_ctrl
    import frame_seq_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int LINK_WORDS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [1:0]      op_i,
    input  logic [XLEN-1:0] fp_i,
    input  logic [XLEN-1:0] sp_i,
    input  logic [XLEN-1:0] ret_addr_i,
    input  logic [XLEN-1:0] target_i,
    input  logic            mem_ready_i,
    input  logic [XLEN-1:0] mem_rdata_i,
    output fs_state_e       state_o,
    output logic [XLEN-1:0] sp_o,
    output logic [XLEN-1:0] fp_o,
    output logic [XLEN-1:0] pc_o,
    output logic [XLEN-1:0] link_o,
    output logic            done_o
);
    localparam int              WORD_BYTES = XLEN / 8;
    localparam logic [XLEN-1:0] WORD_STEP  = XLEN'(WORD_BYTES);
    localparam logic [XLEN-1:0] LINK_STEP  = XLEN'(LINK_WORDS * WORD_BYTES);

    typedef struct packed {
        fs_state_e       st;
        logic [XLEN-1:0] sp;
        logic [XLEN-1:0] fp;
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] link;
        logic [XLEN-1:0] tgt;
        logic            done;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    always_comb begin
        ctx_d      = ctx_q;
        ctx_d.done = 1'b0;
        unique case (ctx_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    case (fs_op_e'(op_i))
                        FS_CALL_IMM, FS_CALL_REG: begin
                            ctx_d.st   = ST_PUSH_LINK;
                            ctx_d.sp   = sp_i - LINK_STEP;
                            ctx_d.fp   = fp_i;
                            ctx_d.link = ret_addr_i;
                            ctx_d.tgt  = target_i;
                        end
                        FS_RETURN: begin
                            ctx_d.st = ST_POP_FRAME;
                            ctx_d.sp = fp_i;
                            ctx_d.fp = fp_i;
                        end
                        default: ;
                    endcase
                end
            end
            ST_PUSH_LINK: begin
                if (mem_ready_i) begin
                    ctx_d.sp = ctx_q.sp - WORD_STEP;
                    ctx_d.st = ST_PUSH_FRAME;
                end
            end
            ST_PUSH_FRAME: begin
                if (mem_ready_i) begin
                    ctx_d.fp   = ctx_q.sp;
                    ctx_d.pc   = ctx_q.tgt;
                    ctx_d.st   = ST_IDLE;
                    ctx_d.done = 1'b1;
                end
            end
            ST_POP_FRAME: begin
                if (mem_ready_i) begin
                    ctx_d.fp = mem_rdata_i;
                    ctx_d.sp = ctx_q.sp + WORD_STEP;
                    ctx_d.st = ST_POP_LINK;
                end
            end
            ST_POP_LINK: begin
                if (mem_ready_i) begin
                    ctx_d.pc   = mem_rdata_i;
                    ctx_d.sp   = ctx_q.sp + LINK_STEP;
                    ctx_d.st   = ST_IDLE;
                    ctx_d.done = 1'b1;
                end
            end
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '{st: ST_IDLE, default: '0};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign state_o = ctx_q.st;
    assign sp_o    = ctx_q.sp;
    assign fp_o    = ctx_q.fp;
    assign pc_o    = ctx_q.pc;
    assign link_o  = ctx_q.link;
    assign done_o  = ctx_q.done;
endmodule

// File: rtl/frame_seq_memport.sv
module frame_seq_memport
    import frame_seq_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  fs_state_e       state_i,
    input  logic [XLEN-1:0] sp_i,
    input  logic [XLEN-1:0] fp_i,
    input  logic [XLEN-1:0] link_i,
    output logic            req_o,
    output logic            we_o,
    output logic [XLEN-1:0] addr_o,
    output logic [XLEN-1:0] wdata_o
);
    always_comb begin
        req_o   = 1'b0;
        we_o    = 1'b0;
        wdata_o = '0;
        // every access targets the working stack top
        addr_o  = sp_i;
        unique case (state_i)
            ST_PUSH_LINK: begin
                req_o   = 1'b1;
                we_o    = 1'b1;
                wdata_o = link_i;
            end
            ST_PUSH_FRAME: begin
                req_o   = 1'b1;
                we_o    = 1'b1;
                wdata_o = fp_i;
            end
            ST_POP_FRAME, ST_POP_LINK: begin
                req_o = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/frame_seq.sv
module frame_seq
    import frame_seq_pkg::*;
#(
    parameter int XLEN        = 32,
    parameter int LINK_WORDS  = 2,
    parameter int SHORT_BYTES = 2,
    parameter int LONG_BYTES  = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [1:0]      op_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] imm_i,
    input  logic [XLEN-1:0] reg_tgt_i,
    input  logic [XLEN-1:0] fp_i,
    input  logic [XLEN-1:0] sp_i,
    output logic            mem_req_o,
    output logic            mem_we_o,
    output logic [XLEN-1:0] mem_addr_o,
    output logic [XLEN-1:0] mem_wdata_o,
    input  logic [XLEN-1:0] mem_rdata_i,
    input  logic            mem_ready_i,
    output logic [XLEN-1:0] fp_o,
    output logic [XLEN-1:0] sp_o,
    output logic [XLEN-1:0] pc_o,
    output logic            done_o,
    output logic            busy_o
);
    fs_state_e       state;
    logic [XLEN-1:0] ret_addr, target, link;

    frame_seq_launch #(
        .XLEN(XLEN), .SHORT_BYTES(SHORT_BYTES), .LONG_BYTES(LONG_BYTES)
    ) u_launch (
        .op_i(op_i), .pc_i(pc_i), .imm_i(imm_i), .reg_tgt_i(reg_tgt_i),
        .ret_addr_o(ret_addr), .target_o(target)
    );

    frame_seq_ctrl #(.XLEN(XLEN), .LINK_WORDS(LINK_WORDS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .fp_i(fp_i), .sp_i(sp_i), .ret_addr_i(ret_addr), .target_i(target),
        .mem_ready_i(mem_ready_i), .mem_rdata_i(mem_rdata_i),
        .state_o(state), .sp_o(sp_o), .fp_o(fp_o), .pc_o(pc_o),
        .link_o(link), .done_o(done_o)
    );

    frame_seq_memport #(.XLEN(XLEN)) u_mem (
        .state_i(state), .sp_i(sp_o), .fp_i(fp_o), .link_i(link),
        .req_o(mem_req_o), .we_o(mem_we_o), .addr_o(mem_addr_o),
        .wdata_o(mem_wdata_o)
    );

    assign busy_o = (state != ST_IDLE);
endmodule

// File: rtl/frame_seq_chk.sv
module frame_seq_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic [1:0]      op_i,
    input logic            mem_req_o,
    input logic            mem_we_o,
    input logic [XLEN-1:0] mem_addr_o,
    input logic [XLEN-1:0] mem_wdata_o,
    input logic            mem_ready_i,
    input logic [XLEN-1:0] fp_o,
    input logic [XLEN-1:0] sp_o,
    input logic            done_o,
    input logic            busy_o
);
    logic was_call_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            was_call_q <= 1'b0;
        end else if (start_i && !busy_o && op_i != 2'b11) begin
            was_call_q <= !op_i[1];
        end
    end

    // R6
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o)
            && $stable(mem_we_o) && $stable(mem_wdata_o));

    // R6
    req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> busy_o);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R8
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && start_i && !(mem_req_o && mem_ready_i) |=> busy_o);

    // R4
    call_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && was_call_q |-> fp_o == sp_o);
endmodule

bind frame_seq frame_seq_chk #(.XLEN(XLEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ready_i(mem_ready_i),
    .fp_o(fp_o), .sp_o(sp_o), .done_o(done_o), .busy_o(busy_o)
);

// File: tb/sim_frame_seq.sv
module sim_frame_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  op_i = 2'b11;
    logic [31:0] pc_i = '0, imm_i = '0, reg_tgt_i = '0, fp_i = '0, sp_i = '0;
    logic        mem_req_o, mem_we_o, done_o, busy_o;
    logic [31:0] mem_addr_o, mem_wdata_o, fp_o, sp_o, pc_o;
    logic [31:0] mem_rdata_i = '0;
    logic        mem_ready_i = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_seq u0 (.*);

    int nchk = 0, nfail = 0, ncycles = 0;

    // behavioural reference state
    logic [31:0] mem [logic [31:0]];
    bit          q_we[$];
    logic [31:0] q_addr[$];
    logic [31:0] q_data[$];
    string       q_tag[$];
    bit          m_busy = 0, done_exp = 0;
    logic [31:0] e_fp = '0, e_sp = '0, e_pc = '0;
    string       res_tag = "R1 reset value";
    bit          slow = 0, stall_seen = 0;
    logic [31:0] stall_addr = '0;

    bit          st_req = 0;
    logic [1:0]  op_n = 2'b11;
    logic [31:0] pc_n = '0, imm_n = '0, rt_n = '0, fp_n = '0, sp_n = '0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic tick();
        @(negedge clk);
        ncycles++;
        chk(done_o === done_exp, "R7 done pulse", 32'(done_o), 32'(done_exp));
        chk(busy_o === m_busy, "R2 R8 busy state", 32'(busy_o), 32'(m_busy));
        chk(mem_req_o === m_busy, "R6 request only while busy", 32'(mem_req_o), 32'(m_busy));
        if (!m_busy) begin
            chk(fp_o === e_fp, {res_tag, " fp"}, fp_o, e_fp);
            chk(sp_o === e_sp, {res_tag, " sp"}, sp_o, e_sp);
            chk(pc_o === e_pc, {res_tag, " pc"}, pc_o, e_pc);
        end
        if (stall_seen && mem_req_o)
            chk(mem_addr_o === stall_addr, "R6 address held in stall", mem_addr_o, stall_addr);
        done_exp = 0;
        stall_seen = 0;
        // drive inputs for the next edge
        start_i   = st_req;
        op_i      = op_n;
        pc_i      = pc_n;
        imm_i     = imm_n;
        reg_tgt_i = rt_n;
        fp_i      = fp_n;
        sp_i      = sp_n;
        mem_ready_i = slow ? ($urandom_range(0, 2) == 0) : 1'b1;
        if (mem_req_o) mem_rdata_i = rd(mem_addr_o);
        // predict the next edge
        if (st_req && !m_busy && op_n != 2'b11) begin
            m_busy = 1;
            if (op_n != 2'b10) begin
                logic [31:0] ra, tg;
                ra = pc_n + ((op_n == 2'b00) ? 32'd6 : 32'd2);
                tg = (op_n == 2'b00) ? imm_n : rt_n;
                q_we.push_back(1); q_addr.push_back(sp_n - 32'd8);
                q_data.push_back(ra); q_tag.push_back("R3 return-address push");
                q_we.push_back(1); q_addr.push_back(sp_n - 32'd12);
                q_data.push_back(fp_n); q_tag.push_back("R4 frame push");
                e_fp = sp_n - 32'd12; e_sp = sp_n - 32'd12; e_pc = tg;
                res_tag = "R4 call result";
            end else begin
                q_we.push_back(0); q_addr.push_back(fp_n);
                q_data.push_back('0); q_tag.push_back("R5 frame pop");
                q_we.push_back(0); q_addr.push_back(fp_n + 32'd4);
                q_data.push_back('0); q_tag.push_back("R5 link pop");
                e_fp = rd(fp_n); e_pc = rd(fp_n + 32'd4); e_sp = fp_n + 32'd12;
                res_tag = "R5 return result";
            end
        end
        if (mem_req_o && !mem_ready_i) begin
            stall_seen = 1;
            stall_addr = mem_addr_o;
        end
        if (mem_req_o && mem_ready_i && q_we.size() > 0) begin
            chk(mem_we_o === q_we[0], {q_tag[0], " direction"}, 32'(mem_we_o), 32'(q_we[0]));
            chk(mem_addr_o === q_addr[0], {q_tag[0], " address"}, mem_addr_o, q_addr[0]);
            if (q_we[0]) begin
                chk(mem_wdata_o === q_data[0], {q_tag[0], " data"}, mem_wdata_o, q_data[0]);
                mem[q_addr[0]] = q_data[0];
            end
            void'(q_we.pop_front()); void'(q_addr.pop_front());
            void'(q_data.pop_front()); void'(q_tag.pop_front());
            if (q_we.size() == 0) begin
                m_busy = 0;
                done_exp = 1;
            end
        end
    endtask

    task automatic run_op(input logic [1:0] op, input logic [31:0] pc, imm, rt, fp, sp, input bit inject);
        int k;
        op_n = op; pc_n = pc; imm_n = imm; rt_n = rt; fp_n = fp; sp_n = sp;
        st_req = 1;
        tick();
        st_req = 0;
        k = 0;
        while (m_busy) begin
            k++;
            if (inject && k == 1) begin
                // R8: foreign start with different operands mid-sequence
                st_req = 1;
                op_n = (op == 2'b10) ? 2'b00 : 2'b10;
                fp_n = 32'hDEAD_0000; sp_n = 32'hBEEF_0000; pc_n = 32'h1234_0000;
            end
            tick();
            st_req = 0;
        end
        tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=%0d expected=<100000", ncycles);
        $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] f0, s0, fa, fb;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(fp_o === 0 && sp_o === 0 && pc_o === 0, "R1 reset pointers", fp_o | sp_o | pc_o, 0);
        chk(!done_o && !busy_o && !mem_req_o, "R1 reset flags", {29'd0, done_o, busy_o, mem_req_o}, 0);
        rst_n = 1'b1;
        repeat (2) tick();

        // immediate call then matching return (R3 R4 R5 R9)
        run_op(2'b00, 32'h400, 32'h8000, 32'h0, 32'h1000, 32'h2000, 0);
        chk(mem[32'h1FF8] === 32'h406, "R3 immediate-call link word", mem[32'h1FF8], 32'h406);
        run_op(2'b10, e_pc, 32'h0, 32'h0, e_fp, e_sp, 0);
        chk(fp_o === 32'h1000, "R9 fp restored", fp_o, 32'h1000);
        chk(sp_o === 32'h2000, "R9 sp restored", sp_o, 32'h2000);
        chk(pc_o === 32'h406, "R5 pc from link", pc_o, 32'h406);

        // register call (R3 R4)
        run_op(2'b01, 32'h500, 32'hFFFF, 32'h9000, 32'h3000, 32'h4000, 0);
        chk(pc_o === 32'h9000, "R4 register target", pc_o, 32'h9000);
        chk(mem[32'h3FF8] === 32'h502, "R3 register-call link word", mem[32'h3FF8], 32'h502);
        run_op(2'b10, e_pc, 0, 0, e_fp, e_sp, 0);

        // R2: reserved code does nothing
        run_op(2'b11, 32'h700, 32'h1, 32'h2, 32'h3, 32'h4, 0);

        // nested calls with irregular ready (R6 R9)
        slow = 1;
        f0 = 32'h5000; s0 = 32'h6000;
        run_op(2'b00, 32'h100, 32'hA000, 0, f0, s0, 0);
        fa = e_fp;
        run_op(2'b01, e_pc, 0, 32'hB000, e_fp, e_sp, 0);
        fb = e_fp;
        run_op(2'b00, e_pc, 32'hC000, 0, e_fp, e_sp, 0);
        chk(mem[e_fp] === fb, "R9 chain level 3", mem[e_fp], fb);
        chk(mem[fb] === fa, "R9 chain level 2", mem[fb], fa);
        chk(mem[fa] === f0, "R9 chain level 1", mem[fa], f0);
        run_op(2'b10, e_pc, 0, 0, e_fp, e_sp, 0);
        run_op(2'b10, e_pc, 0, 0, e_fp, e_sp, 0);
        run_op(2'b10, e_pc, 0, 0, e_fp, e_sp, 0);
        chk(fp_o === f0, "R9 nested fp restored", fp_o, f0);
        chk(sp_o === s0, "R9 nested sp restored", sp_o, s0);
        chk(pc_o === 32'h106, "R9 nested pc restored", pc_o, 32'h106);

        // R8: starts during busy are ignored, both directions
        slow = 0;
        run_op(2'b00, 32'h200, 32'hD000, 0, 32'h7000, 32'h7800, 1);
        run_op(2'b10, e_pc, 0, 0, e_fp, e_sp, 1);
        chk(sp_o === 32'h7800, "R8 return after ignored start", sp_o, 32'h7800);
        slow = 1;
        run_op(2'b01, 32'h300, 0, 32'hE000, 32'h7000, 32'h7800, 1);
        run_op(2'b10, e_pc, 0, 0, e_fp, e_sp, 1);

        // address wrap below zero (R3 R4)
        slow = 0;
        run_op(2'b00, 32'h10, 32'h20, 0, 32'h44, 32'h8, 0);
        chk(sp_o === 32'hFFFF_FFFC, "R4 wrapped stack top", sp_o, 32'hFFFF_FFFC);
        run_op(2'b10, e_pc, 0, 0, e_fp, e_sp, 0);
        chk(sp_o === 32'h8, "R9 wrapped sp restored", sp_o, 32'h8);

        repeat (3) tick();
        $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule